// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces the line sync, frame sync, display-enable and frame-start signals for a raster display. It is clocked by the pixel clock. The horizontal and vertical positions are not kept in binary counters. Each one lives in a 16-bit linear feedback shift register, so the next-state logic of either counter is one XOR gate deep no matter how wide the count is.

Every programmed event position is supplied as the shift-register state that the counter reaches after N steps from its all-ones seed, where N is the wanted binary position. These positions are the line end, the frame end, the sync on/off points and the display window edges. Equality comparators match each programmed state against the live counter. Each pair of on/off matches drives a window flag. All outputs are registered from the flags, so they change together on one pixel-clock edge.

A blanking control either lets the syncs and display enable run or holds them low. While they are held low, the counters keep their place.

Top module: `lfsr_raster_timer`

## Requirements
- R1: While `rst` is high at a clock edge, both position counters return to the all-ones seed and `hsyncO`, `vsyncO`, `deO` and `frameStartO` are low after that edge.
- R2: Each counter step shifts its state left by one bit. The new bit 0 is the XOR of bits 15, 4, 2 and 1 of the old state. Position N therefore means the state reached after N steps from 0xFFFF, for any N up to at least several hundred.
- R3: Each pixel clock advances the horizontal counter. When it equals `hEndCnt` (position L), it returns to the seed on the next edge, so a line lasts L+1 pixel clocks.
- R4: The vertical counter advances only on the edge where the horizontal counter wraps. When it equals `vEndCnt` (position M) at that edge, it returns to the seed, so a frame lasts M+1 lines.
- R5: `hsyncO` is high exactly in the cycles that follow a cycle whose horizontal position p satisfies start <= p < end. Here start and end are the positions held in `hSyncOn` and `hSyncOff`, with start < end <= L.
- R6: `vsyncO` is high exactly in the cycles that follow a cycle whose vertical position q satisfies start <= q < end. Here start and end are the positions held in `vSyncOn` and `vSyncOff`, with start < end <= M.
- R7: `deO` is high exactly in the cycles that follow a cycle where the horizontal position lies in [`xShowOn`, `xShowOff`) and the vertical position lies in [`yShowOn`, `yShowOff`), both as positions.
- R8: With `blankMode` equal to 0x00 the syncs and display enable run normally. With any other value, for example 0x01 or 0x07, they are low in the cycle after. The counters and `frameStartO` keep running unchanged.
- R9: `frameStartO` is a one-cycle pulse. It is high in the cycle after a cycle in which both counters hold the seed.
- R10: All four outputs are registered. In every cycle they reflect the counter positions and `blankMode` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hEndCnt | input | 16 | Shift-register state of the last pixel of a line |
| hSyncOn | input | 16 | State at which line sync begins |
| hSyncOff | input | 16 | State at which line sync ends |
| xShowOn | input | 16 | State at which the horizontal display window opens |
| xShowOff | input | 16 | State at which the horizontal display window closes |
| vEndCnt | input | 16 | Shift-register state of the last line of a frame |
| vSyncOn | input | 16 | State at which frame sync begins |
| vSyncOff | input | 16 | State at which frame sync ends |
| yShowOn | input | 16 | State at which the vertical display window opens |
| yShowOff | input | 16 | State at which the vertical display window closes |
| blankMode | input | 8 | 0x00 runs the outputs, any other value blanks them |
| hsyncO | output | 1 | Line sync, active high |
| vsyncO | output | 1 | Frame sync, active high |
| deO | output | 1 | Display enable |
| frameStartO | output | 1 | One-cycle pulse at the frame origin |

## Verification
The hardest case to reach from the ports is a programmed position that lies hundreds of steps from the seed. Only a long walk of the shift register produces such a state, and a wrong tap spoils it without affecting the short counts. The stimulus programs a line length of 300 pixels, with its states computed by an independent stepping function, and checks the measured line and frame periods. A blanking change in the middle of a frame, and windows that open right at the seed state, cover the other awkward corners. A cycle-level reference model tracks binary positions and is compared against every output in every cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int POS_W = 16;
  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t SEED = '1;
  // feedback taps: bits 15, 4, 2, 1
  localparam pos_t TAP_MASK = 16'h8016;

  localparam int NWIN   = 4;
  localparam int WIN_HS = 0;
  localparam int WIN_VS = 1;
  localparam int WIN_X  = 2;
  localparam int WIN_Y  = 3;

  typedef struct packed {
    logic            hWrap;
    logic            vWrap;
    logic [NWIN-1:0] winOn;
    logic [NWIN-1:0] winOff;
    logic            atOrigin;
  } strobe_t;

  function automatic pos_t lfsrNext(pos_t cur);
    return {cur[POS_W-2:0], ^(cur & TAP_MASK)};
  endfunction
endpackage

// File: rtl/raster_lfsr_reg.sv
module raster_lfsr_reg
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stepEn,
  input  logic wrapEn,
  output pos_t pos
);
  always_ff @(posedge clk) begin
    if (rst)         pos <= SEED;
    else if (stepEn) pos <= wrapEn ? SEED : lfsrNext(pos);
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) pos != '0);
endmodule

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  pos_t            hPos,
  input  pos_t            vPos,
  input  pos_t            hEnd,
  input  pos_t            vEnd,
  input  pos_t [NWIN-1:0] onPos,
  input  pos_t [NWIN-1:0] offPos,
  output strobe_t         strb
);
  logic hAtEnd;
  assign hAtEnd = (hPos == hEnd);

  always_comb begin
    strb.hWrap    = hAtEnd;
    strb.vWrap    = hAtEnd && (vPos == vEnd);
    strb.atOrigin = (hPos == SEED) && (vPos == SEED);
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    localparam bit USE_V = (i == WIN_VS) || (i == WIN_Y);
    if (USE_V) begin : g_v
      assign strb.winOn[i]  = (vPos == onPos[i]);
      assign strb.winOff[i] = (vPos == offPos[i]);
    end else begin : g_h
      assign strb.winOn[i]  = (hPos == onPos[i]);
      assign strb.winOff[i] = (hPos == offPos[i]);
    end
  end

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hAtEnd |=> (hPos == SEED));
  // R4
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hAtEnd |=> $stable(vPos));
  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hAtEnd && (vPos == vEnd)) |=> ((hPos == SEED) && (vPos == SEED)));
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strb,
  input  logic [7:0] blankMode,
  output pos_t       hPos,
  output pos_t       vPos,
  output logic       hsyncO,
  output logic       vsyncO,
  output logic       deO,
  output logic       frameStartO
);
  logic            live;
  logic [NWIN-1:0] winQ;
  logic [NWIN-1:0] winD;

  assign live = (blankMode == 8'h00);

  raster_lfsr_reg u_hCnt (
    .clk(clk), .rst(rst), .stepEn(1'b1), .wrapEn(strb.hWrap), .pos(hPos));

  raster_lfsr_reg u_vCnt (
    .clk(clk), .rst(rst), .stepEn(strb.hWrap), .wrapEn(strb.vWrap), .pos(vPos));

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_comb begin
      if (strb.winOn[i])       winD[i] = 1'b1;
      else if (strb.winOff[i]) winD[i] = 1'b0;
      else                     winD[i] = winQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winQ        <= '0;
      hsyncO      <= 1'b0;
      vsyncO      <= 1'b0;
      deO         <= 1'b0;
      frameStartO <= 1'b0;
    end else begin
      winQ        <= winD;
      hsyncO      <= winD[WIN_HS] && live;
      vsyncO      <= winD[WIN_VS] && live;
      deO         <= winD[WIN_X] && winD[WIN_Y] && live;
      frameStartO <= strb.atOrigin;
    end
  end

  // R8
  blank_force_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(blankMode) != 8'h00) |-> (!hsyncO && !vsyncO && !deO));
endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
  import raster_pkg::*;
(
  input  logic        pixClk,
  input  logic        rst,
  input  logic [15:0] hEndCnt,
  input  logic [15:0] hSyncOn,
  input  logic [15:0] hSyncOff,
  input  logic [15:0] xShowOn,
  input  logic [15:0] xShowOff,
  input  logic [15:0] vEndCnt,
  input  logic [15:0] vSyncOn,
  input  logic [15:0] vSyncOff,
  input  logic [15:0] yShowOn,
  input  logic [15:0] yShowOff,
  input  logic [7:0]  blankMode,
  output logic        hsyncO,
  output logic        vsyncO,
  output logic        deO,
  output logic        frameStartO
);
  pos_t            hPos;
  pos_t            vPos;
  strobe_t         strb;
  pos_t [NWIN-1:0] onPos;
  pos_t [NWIN-1:0] offPos;

  always_comb begin
    onPos[WIN_HS]  = hSyncOn;
    offPos[WIN_HS] = hSyncOff;
    onPos[WIN_VS]  = vSyncOn;
    offPos[WIN_VS] = vSyncOff;
    onPos[WIN_X]   = xShowOn;
    offPos[WIN_X]  = xShowOff;
    onPos[WIN_Y]   = yShowOn;
    offPos[WIN_Y]  = yShowOff;
  end

  raster_ctrl u_ctrl (
    .clk(pixClk), .rst(rst), .hPos(hPos), .vPos(vPos),
    .hEnd(hEndCnt), .vEnd(vEndCnt), .onPos(onPos), .offPos(offPos),
    .strb(strb));

  raster_datapath u_dp (
    .clk(pixClk), .rst(rst), .strb(strb), .blankMode(blankMode),
    .hPos(hPos), .vPos(vPos), .hsyncO(hsyncO), .vsyncO(vsyncO),
    .deO(deO), .frameStartO(frameStartO));
endmodule

// File: tb/lfsr_raster_timer_tb_top.sv
module lfsr_raster_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] hEndCnt = '1, hSyncOn = '1, hSyncOff = '1, xShowOn = '1, xShowOff = '1;
  logic [15:0] vEndCnt = '1, vSyncOn = '1, vSyncOff = '1, yShowOn = '1, yShowOff = '1;
  logic [7:0]  blankMode = 8'h00;
  logic        hsyncO, vsyncO, deO, frameStartO;

  always #5 clk = ~clk;

  lfsr_raster_timer dut_i (
    .pixClk(clk), .rst(rst), .hEndCnt(hEndCnt), .hSyncOn(hSyncOn), .hSyncOff(hSyncOff),
    .xShowOn(xShowOn), .xShowOff(xShowOff), .vEndCnt(vEndCnt), .vSyncOn(vSyncOn),
    .vSyncOff(vSyncOff), .yShowOn(yShowOn), .yShowOff(yShowOff), .blankMode(blankMode),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .frameStartO(frameStartO));

  typedef struct packed { logic hs; logic vs; logic de; logic fs; } exp_t;
  exp_t expQ[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  // binary model parameters
  int hLast = 0, vLast = 0, hsA = 0, hsB = 0, xA = 0, xB = 0;
  int vsA = 0, vsB = 0, yA = 0, yB = 0;
  int hIdx = 0, vIdx = 0;

  int cyc = 0, fsPrev = 0, fsLast = 0, hrPrev = 0, hrLast = 0;
  logic hsLvl = 1'b0;

  // R2: step rule, independent of the design
  function automatic logic [15:0] posState(int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit inWin(int p, int a, int b);
    return (p >= a) && (p < b);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // driver model: pushes the expected outputs for the cycle after each edge
  always @(posedge clk) begin
    if (rst) begin
      hIdx = 0;
      vIdx = 0;
    end else begin
      exp_t e;
      bit live;
      live = (blankMode == 8'h00);
      e.hs = live && inWin(hIdx, hsA, hsB);
      e.vs = live && inWin(vIdx, vsA, vsB);
      e.de = live && inWin(hIdx, xA, xB) && inWin(vIdx, yA, yB);
      e.fs = (hIdx == 0) && (vIdx == 0);
      expQ.push_back(e);
      if (hIdx == hLast) begin
        hIdx = 0;
        vIdx = (vIdx == vLast) ? 0 : vIdx + 1;
      end else begin
        hIdx = hIdx + 1;
      end
    end
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      fsPrev = 0; fsLast = 0; hrPrev = 0; hrLast = 0;
    end
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(hsyncO == e.hs, "R5 R8 hsync", int'(hsyncO), int'(e.hs));
      check(vsyncO == e.vs, "R6 R8 vsync", int'(vsyncO), int'(e.vs));
      check(deO == e.de, "R7 R10 display enable", int'(deO), int'(e.de));
      check(frameStartO == e.fs, "R9 R10 frame start", int'(frameStartO), int'(e.fs));
    end
    if (frameStartO) begin fsPrev = fsLast; fsLast = cyc; end
    if (hsyncO && !hsLvl) begin hrPrev = hrLast; hrLast = cyc; end
    hsLvl = hsyncO;
  end

  task automatic setup(int hl, int a0, int a1, int x0, int x1,
                       int vl, int b0, int b1, int y0, int y1);
    @(negedge clk);
    rst = 1'b1;
    blankMode = 8'h00;
    hEndCnt = posState(hl);  hSyncOn = posState(a0); hSyncOff = posState(a1);
    xShowOn = posState(x0);  xShowOff = posState(x1);
    vEndCnt = posState(vl);  vSyncOn = posState(b0); vSyncOff = posState(b1);
    yShowOn = posState(y0);  yShowOff = posState(y1);
    hLast = hl; hsA = a0; hsB = a1; xA = x0; xB = x1;
    vLast = vl; vsA = b0; vsB = b1; yA = y0; yB = y1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!hsyncO && !vsyncO && !deO && !frameStartO, "R1 outputs low in reset",
          int'({hsyncO, vsyncO, deO, frameStartO}), 0);
    rst = 1'b0;
  endtask

  task automatic periods(string req, int lineLen, int frameLen);
    check((hrLast - hrPrev) == lineLen, {req, " R3 line period"}, hrLast - hrPrev, lineLen);
    check((fsLast - fsPrev) == frameLen, {req, " R4 frame period"}, fsLast - fsPrev, frameLen);
  endtask

  initial begin
    // config A: 20-pixel lines, 9-line frame
    setup(19, 1, 4, 6, 16, 8, 0, 2, 3, 7);
    repeat (400) @(negedge clk);
    periods("A", 20, 180);
    // R8: blank mid-frame, two nonzero modes, then resume
    blankMode = 8'h01;
    repeat (200) @(negedge clk);
    check(fsLast - fsPrev == 180, "R8 frame start continues while blanked", fsLast - fsPrev, 180);
    blankMode = 8'h07;
    repeat (97) @(negedge clk);
    blankMode = 8'h00;
    repeat (250) @(negedge clk);
    periods("R8 resume", 20, 180);
    // config B: long line, state far from the seed
    setup(299, 1, 45, 50, 290, 2, 0, 1, 1, 2);
    repeat (2000) @(negedge clk);
    periods("R2 long line", 300, 900);
    // config C: windows opening at the seed position
    setup(7, 0, 7, 0, 4, 3, 0, 3, 0, 3);
    repeat (200) @(negedge clk);
    periods("C seed windows", 8, 32);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule